// File: doc/BRIEF.md
# Dual-Enable Asynchronous SRAM Controller

This block sits between a simple internal request port and an external asynchronous static RAM that has two chip enables of opposite polarity (one active low, one active high), an active-low write enable and an active-low output enable. Each accepted request becomes a fixed pin sequence of four phases: setup, pulse, hold and turnaround. The length of each phase is a parameter counted in clock cycles. A one-hot state machine steps through the phases in the order IDLE, SETUP, PULSE, HOLD, TURNAROUND, then returns to IDLE.

A write keeps both chip enables asserted from setup through hold. It drives the data bus for that whole span and pulses write enable low only in the pulse phase. The RAM therefore latches the data on the rising edge of write enable, while both the address and the data are still held. A read asserts output enable during the pulse phase and samples the RAM data in the last cycle of that phase. It then raises a one-cycle valid strobe. Between operations both chip enables are held in their deasserted state, which keeps the RAM in standby.

The request port is a valid/ready handshake. Ready is high only in IDLE, and a request is taken on a clock edge where both valid and ready are high.

Top module: `sram_ctl`

## Requirements
- R1: In reset and whenever idle, the controller holds ram_ce_n=1, ram_ce=0, ram_we_n=1, ram_oe_n=1, ram_dq_oe=0 and req_ready=1.
- R2: A request is accepted only while req_ready=1. req_ready stays 0 from the cycle after acceptance until the operation ends, and req_valid has no effect in that time: the address, the enables and the stored data are unchanged by it.
- R3: A write holds both chip enables asserted and write enable high for T_SETUP cycles. It then holds ram_we_n=0 for T_PULSE cycles, then keeps write enable high for T_HOLD cycles with the data and address unchanged.
- R4: ram_oe_n is 1 in every cycle where ram_we_n is 0. ram_dq_oe is 1 only in a cycle where ram_oe_n is 1 in that cycle and in the cycle before.
- R5: ram_addr changes only on the clock edge that accepts a request. It is never changed while ram_we_n is 0.
- R6: A read holds ram_oe_n=0 for T_ACCESS cycles after T_SETUP setup cycles. It then raises rd_valid for exactly one cycle, the first cycle after the access phase, with rd_data equal to ram_dq_in as sampled in the last access cycle.
- R7: After the hold phase, T_TURN cycles of standby follow before req_ready returns to 1. An operation therefore keeps req_ready at 0 for T_SETUP + (T_PULSE or T_ACCESS) + T_HOLD + T_TURN cycles.
- R8: The value stored in the RAM at the rising edge of write enable is the req_wdata and req_addr given with the accepted write.
- R9: A read of an address returns the value most recently written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle strobe marking read data |
| rd_data | output | DW | Captured read data |
| ram_addr | output | AW | RAM address bus |
| ram_ce_n | output | 1 | Active-low chip enable |
| ram_ce | output | 1 | Active-high chip enable |
| ram_we_n | output | 1 | Active-low write enable |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_dq_out | output | DW | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for ram_dq_out |
| ram_dq_in | input | DW | Data returned from the RAM |

## Verification
Some rules are checked by assertions on every cycle:
- write enable is low only when output enable is off and both chip enables are asserted;
- the data bus is driven only after output enable has been off for a full cycle;
- the address never moves during a write pulse or a busy interval;
- data and address are still held on the cycle write enable rises;
- the read strobe lasts one cycle and follows an access cycle;
- the state vector stays one-hot.

Other behaviour can only be shown by the bench's scenarios against a RAM model:
- the exact phase lengths;
- the data actually stored and read back;
- requests ignored while busy;
- a read followed at once by a write, which has to pass through the turnaround.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int T_SETUP  = 1,
  parameter int T_PULSE  = 2,
  parameter int T_HOLD   = 1,
  parameter int T_ACCESS = 2,
  parameter int T_TURN   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] ram_addr,
  output logic          ram_ce_n,
  output logic          ram_ce,
  output logic          ram_we_n,
  output logic          ram_oe_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);

  localparam int TM1  = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int TM2  = (T_HOLD > T_ACCESS) ? T_HOLD : T_ACCESS;
  localparam int TM3  = (TM1 > TM2) ? TM1 : TM2;
  localparam int TMAX = (TM3 > T_TURN) ? TM3 : T_TURN;
  localparam int CW   = (TMAX > 1) ? $clog2(TMAX) : 1;

  localparam int I_IDLE = 0;
  localparam int I_SET  = 1;
  localparam int I_PUL  = 2;
  localparam int I_HLD  = 3;
  localparam int I_TRN  = 4;

  logic [4:0]    st;
  logic [CW-1:0] cnt;
  logic          op_wr;
  logic [DW-1:0] wdat;

  wire last   = (cnt == '0);
  wire accept = st[I_IDLE] & req_valid;
  wire active = st[I_SET] | st[I_PUL] | st[I_HLD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= 5'b00001;
      cnt      <= '0;
      op_wr    <= 1'b0;
      wdat     <= '0;
      ram_addr <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (accept) begin
        st       <= 5'b00010;
        cnt      <= CW'(T_SETUP - 1);
        op_wr    <= req_write;
        ram_addr <= req_addr;
        wdat     <= req_wdata;
      end else if (!st[I_IDLE]) begin
        if (!last) begin
          cnt <= cnt - 1'b1;
        end else if (st[I_SET]) begin
          st  <= 5'b00100;
          cnt <= op_wr ? CW'(T_PULSE - 1) : CW'(T_ACCESS - 1);
        end else if (st[I_PUL]) begin
          st  <= 5'b01000;
          cnt <= CW'(T_HOLD - 1);
          if (!op_wr) begin
            rd_data  <= ram_dq_in;
            rd_valid <= 1'b1;
          end
        end else if (st[I_HLD]) begin
          st  <= 5'b10000;
          cnt <= CW'(T_TURN - 1);
        end else begin
          st  <= 5'b00001;
        end
      end
    end
  end

  assign req_ready  = st[I_IDLE];
  assign ram_ce_n   = ~active;
  assign ram_ce     = active;
  assign ram_we_n   = ~(st[I_PUL] & op_wr);
  assign ram_oe_n   = ~(st[I_PUL] & ~op_wr);
  assign ram_dq_oe  = op_wr & active;
  assign ram_dq_out = wdat;

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n && !ram_ce && ram_we_n && ram_oe_n && !ram_dq_oe)); // R1
  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(st)); // R2
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_ce_n && ram_ce && ram_dq_oe)); // R3
  AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (ram_dq_oe && $stable(ram_dq_out) && $stable(ram_addr))); // R3
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ram_oe_n); // R4
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (ram_oe_n && $past(ram_oe_n))); // R4
  AST_ADDR_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> $stable(ram_addr)); // R5
  AST_ADDR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(ram_addr)); // R5
  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R6
  AST_RDV_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (ram_oe_n && !$past(ram_oe_n))); // R6
  AST_TURN_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $past(ram_ce_n)); // R7

endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;
  localparam int AW = 18, DW = 16;
  localparam int TS = 2, TP = 3, TH = 1, TA = 2, TT = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ram_ce_n, ram_ce, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [DW-1:0] rd_data, ram_dq_out, ram_dq_in;
  logic [AW-1:0] ram_addr;

  int total = 0, bad = 0, viol = 0;
  logic [DW-1:0] mem [64];
  logic prev_oe_n = 1'b1;

  always #10 clk = ~clk;

  sram_ctl #(.AW(AW), .DW(DW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH),
             .T_ACCESS(TA), .T_TURN(TT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_ce(ram_ce), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in));

  always @(posedge ram_we_n)
    if (ram_ce_n === 1'b0 && ram_ce === 1'b1) mem[ram_addr[5:0]] = ram_dq_out;

  assign ram_dq_in = (!ram_ce_n && ram_ce && !ram_oe_n && ram_we_n) ? mem[ram_addr[5:0]] : 16'hDEAD;

  always @(negedge clk) begin
    if (rst_n && ram_dq_oe && (!ram_oe_n || !prev_oe_n)) viol++;
    prev_oe_n <= ram_oe_n;
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int busy = 0, lo = 0, first_lo = -1, rv = 0, rv_idx = -1, dmis = 0, amis = 0;
    logic [DW-1:0] got = '0;
    logic last_sb = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~d;
    while (!req_ready && busy < 100) begin
      if (ram_addr !== a) amis++;
      if (wr ? !ram_we_n : !ram_oe_n) begin
        if (first_lo < 0) first_lo = busy;
        lo++;
        if (wr && ram_dq_out !== d) dmis++;
      end
      if (rd_valid) begin rv++; rv_idx = busy; got = rd_data; end
      last_sb = ram_ce_n && !ram_ce;
      busy++;
      @(negedge clk);
    end
    chk(busy == TS + (wr ? TP : TA) + TH + TT, "R7 busy length", busy, TS + (wr ? TP : TA) + TH + TT);
    chk(last_sb, "R7 standby in turnaround", last_sb, 1);
    chk(amis == 0, "R5 address held", amis, 0);
    chk(first_lo == TS, wr ? "R3 pulse start" : "R6 access start", first_lo, TS);
    chk(lo == (wr ? TP : TA), wr ? "R3 pulse length" : "R6 access length", lo, wr ? TP : TA);
    if (wr) begin
      chk(dmis == 0, "R3 data during pulse", dmis, 0);
      chk(mem[a[5:0]] === d, "R8 stored data", mem[a[5:0]], d);
    end else begin
      chk(rv == 1 && rv_idx == TS + TA, "R6 valid strobe", rv_idx, TS + TA);
      chk(got === d, "R9 read data", got, d);
    end
  endtask

  localparam logic [34:0] VEC [10] = '{
    {1'b1, 18'h00003, 16'hA5A5}, {1'b1, 18'h00010, 16'h1234},
    {1'b1, 18'h0003F, 16'hFFFF}, {1'b1, 18'h00000, 16'h0000},
    {1'b0, 18'h00003, 16'hA5A5}, {1'b0, 18'h00010, 16'h1234},
    {1'b1, 18'h00010, 16'hBEEF}, {1'b0, 18'h00010, 16'hBEEF},
    {1'b0, 18'h0003F, 16'hFFFF}, {1'b0, 18'h00000, 16'h0000}};

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && ram_ce_n && !ram_ce && ram_we_n && ram_oe_n && !ram_dq_oe && !rd_valid,
        "R1 reset standby", {ram_ce_n, ram_ce, ram_we_n, ram_oe_n, ram_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && ram_ce_n && !ram_ce && !ram_dq_oe, "R1 idle standby", req_ready, 1);

    for (int i = 0; i < 10; i++) run_op(VEC[i][34], VEC[i][33:16], VEC[i][15:0]);

    // R2: request presented while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h5; req_wdata = 16'h1111;
    @(negedge clk);
    req_addr = 18'h6; req_wdata = 16'h2222;
    chk(!req_ready, "R2 ready low while busy", req_ready, 0);
    repeat (3) @(negedge clk);
    chk(ram_addr === 18'h5, "R2 address unaffected", ram_addr, 18'h5);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    chk(mem[5] === 16'h1111 && mem[6] === 16'h0000, "R2 ignored write", mem[6], 0);
    chk(ram_addr === 18'h5, "R2 address kept", ram_addr, 18'h5);

    // R7/R4: read directly followed by write
    run_op(1'b0, 18'h5, 16'h1111);
    run_op(1'b1, 18'h7, 16'h7777);
    run_op(1'b0, 18'h7, 16'h7777);
    chk(viol == 0, "R4 bus contention", viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule